// File: doc/BRIEF.md
# Two-Thread Fetch Slot Arbiter

This block decides, on every clock cycle, which of two hardware thread contexts owns the single fetch port of a shared instruction front end. It keeps a next-fetch pointer for each thread and presents the chosen thread's ID and byte address to the fetch port. It also reports how many instruction slots remain in that fetch line. Per-thread stall, halt, wake and redirect inputs steer the choice. When both threads can fetch, ownership flips every cycle. A stalled thread gives up its slot to its sibling in the same cycle. A halted thread gives all fetch cycles to its sibling until a wake arrives.

A second, slower selector chooses which thread's buffered bundles feed the shared decoder. The decoder stays on one thread for a quantum of instructions. It moves to the other thread when the quantum is used up, or earlier if the current thread has nothing pending. Instructions are 4 bytes wide. A fetch line is 16 bytes, so one fetch delivers at most four instructions. The instruction cache, the predictor and the decoder are outside the block.

Top module: `smt_fetch_arbiter`

## Requirements
- R1: During and after reset, both pointers hold RESET_VEC (default 0x1000). Thread 0 wins the first fetch cycle, and the decode selector starts on thread 0.
- R2: When both threads are eligible in a cycle that follows a granted cycle, the grant goes to the thread that was not granted last. A thread is eligible when it is neither stalled nor halted. fetch_tid_o is 0 for thread 0 and 1 for thread 1.
- R3: A thread's pointer changes only on a cycle in which it is granted or redirected. On a granted cycle without a redirect, the pointer moves to the start of the next 16-byte line. fetch_addr_o shows the granted thread's pointer in the same cycle.
- R4: If exactly one thread is stalled and the other is eligible, the eligible thread is granted in that same cycle.
- R5: A pulse on halt_i[t] marks thread t halted from the next cycle on. A halted thread is never granted. Every cycle in which its sibling is not stalled goes to the sibling.
- R6: A pulse on wake_i[t] clears the halt of thread t from the next cycle on, and alternation resumes. If wake and halt arrive in the same cycle, wake wins.
- R7: When no thread is eligible, fetch_valid_o is 0 and neither pointer advances.
- R8: A redirect on thread t loads its pointer with the redirect address, low two bits cleared, on the next cycle. The redirect takes priority over the line increment.
- R9: The decode selector counts instructions taken from the current thread (dec_take_i while that thread is pending). After DEC_QUANTUM (default 8) takes, it switches to the other thread if that thread is pending. Otherwise it stays and restarts its count.
- R10: If the current decode thread has nothing pending and the other thread does, the selector switches on the next cycle and its count restarts.
- R11: fetch_slots_o equals 4 minus the word index of fetch_addr_o within its 16-byte line. It is always between 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 2 | Per-thread stall, bit t for thread t |
| halt_i | input | 2 | Per-thread halt request pulse |
| wake_i | input | 2 | Per-thread wake pulse |
| redir_valid_i | input | 2 | Per-thread redirect strobe |
| redir_addr0_i | input | ADDR_W | Redirect target for thread 0 |
| redir_addr1_i | input | ADDR_W | Redirect target for thread 1 |
| dec_pend_i | input | 2 | Thread t has bundles waiting for decode |
| dec_take_i | input | 1 | Decoder consumes one instruction this cycle |
| fetch_valid_o | output | 1 | A fetch is issued this cycle |
| fetch_tid_o | output | 1 | Thread that owns the fetch slot |
| fetch_addr_o | output | ADDR_W | Fetch byte address of that thread |
| fetch_slots_o | output | 3 | Instructions left in the fetch line |
| dec_tid_o | output | 1 | Thread selected for decode |
| dec_valid_o | output | 1 | Selected decode thread has work pending |

## Verification
The hardest case to reach is a halt or wake that lands while the sibling is stalled, or while the halted thread is being redirected. In that case several rules act on the same edge: halt priority, the alternation memory and pointer update order. Random stimulus produces stalls, halt and wake pulses, and redirects at independent rates. Directed sequences also force a wake and a halt in the same cycle, a redirect to a mid-line address, and a decode quantum that expires while the sibling is idle. A bench model predicts every output in every cycle.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;
  typedef logic tid_t;

  localparam int unsigned NUM_THREADS = 2;

  function automatic tid_t sibling(input tid_t t);
    return ~t;
  endfunction
endpackage

// File: rtl/smt_fetch_ptr.sv
module smt_fetch_ptr #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned FETCH_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000,
  localparam int unsigned LINE_BYTES = INSN_BYTES * FETCH_W,
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
  localparam int unsigned ILOG       = $clog2(INSN_BYTES),
  localparam int unsigned SLOT_W     = $clog2(FETCH_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [SLOT_W-1:0] slots_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] redir_aligned;
  logic              advance_evt;

  // start of the following fetch line
  function automatic logic [ADDR_W-1:0] next_line(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] base;
    base = a & ~ADDR_W'(LINE_BYTES - 1);
    return base + ADDR_W'(LINE_BYTES);
  endfunction

  // instructions still left in the line that holds a
  function automatic logic [SLOT_W-1:0] slots_left(input logic [ADDR_W-1:0] a);
    logic [OFF_W-ILOG-1:0] widx;
    widx = a[OFF_W-1:ILOG];
    return SLOT_W'(FETCH_W) - SLOT_W'(widx);
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(INSN_BYTES - 1);
  endfunction

  assign redir_aligned = word_align(redir_addr_i);
  assign advance_evt   = grant_i && !redir_i;

  always_comb begin
    ptr_d = ptr_q;
    if (redir_i)          ptr_d = redir_aligned;
    else if (advance_evt) ptr_d = next_line(ptr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= RESET_VEC;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o   = ptr_q;
  assign slots_o = slots_left(ptr_q);

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_i && !redir_i) |=> $stable(ptr_o));
  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_i |=> (ptr_o == $past(redir_aligned)));
  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance_evt |=> (ptr_o[OFF_W-1:0] == '0) && (ptr_o != $past(ptr_o)));
  p_slots_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (slots_o >= SLOT_W'(1)) && (slots_o <= SLOT_W'(FETCH_W)));
endmodule

// File: rtl/smt_fetch_grant.sv
module smt_fetch_grant
  import smt_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] stall_i,
  input  logic [1:0] halt_i,
  input  logic [1:0] wake_i,
  output logic       valid_o,
  output tid_t       tid_o,
  output logic [1:0] grant_o,
  output logic [1:0] elig_o,
  output logic [1:0] halted_o
);
  logic [1:0] halted_q;
  logic [1:0] elig;
  tid_t       last_q;
  logic       both_ready;
  logic       none_ready;

  // halt state, wake dominates a simultaneous halt
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_halt
    always_ff @(posedge clk) begin
      if (!rst_n)         halted_q[t] <= 1'b0;
      else if (wake_i[t]) halted_q[t] <= 1'b0;
      else if (halt_i[t]) halted_q[t] <= 1'b1;
    end
  end

  assign elig       = ~halted_q & ~stall_i;
  assign both_ready = &elig;
  assign none_ready = ~|elig;

  always_comb begin
    valid_o = !none_ready;
    if (both_ready) tid_o = sibling(last_q);
    else            tid_o = elig[1];
  end

  assign grant_o[0] = valid_o && (tid_o == 1'b0);
  assign grant_o[1] = valid_o && (tid_o == 1'b1);

  // last owner; reset value makes thread 0 win first
  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (valid_o) last_q <= tid_o;
  end

  assign elig_o   = elig;
  assign halted_o = halted_q;

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_halted_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & halted_q) == 2'b00);
  p_wake_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i[0] && halt_i[0]) |=> !halted_q[0]);
  p_halt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i[1] && !wake_i[1]) |=> halted_q[1]);
endmodule

// File: rtl/smt_decode_sel.sv
module smt_decode_sel
  import smt_fetch_pkg::*;
#(
  parameter int unsigned DEC_QUANTUM = 8,
  localparam int unsigned CNT_W = $clog2(DEC_QUANTUM + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend_i,
  input  logic       take_i,
  output tid_t       tid_o,
  output logic       valid_o
);
  tid_t             cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             took;
  logic             quantum_done;
  logic             other_waiting;
  logic             cur_empty;
  logic             switch_evt;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic en);
    return c + CNT_W'(en);
  endfunction

  assign cur_empty     = !pend_i[cur_q];
  assign other_waiting = pend_i[sibling(cur_q)];
  assign took          = take_i && !cur_empty;
  assign cnt_inc       = bump(cnt_q, took);
  assign quantum_done  = (cnt_inc == CNT_W'(DEC_QUANTUM));
  assign switch_evt    = other_waiting && (quantum_done || cur_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else if (switch_evt) begin
      cur_q <= sibling(cur_q);
      cnt_q <= '0;
    end else if (quantum_done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  assign tid_o   = cur_q;
  assign valid_o = !cur_empty;

  p_quantum_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DEC_QUANTUM));
  p_early_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_empty && other_waiting) |=> (tid_o != $past(tid_o)));
  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_empty && !quantum_done) |=> $stable(tid_o));
endmodule

// File: rtl/smt_fetch_arbiter.sv
module smt_fetch_arbiter
  import smt_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned INSN_BYTES  = 4,
  parameter int unsigned FETCH_W     = 4,
  parameter int unsigned DEC_QUANTUM = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000,
  localparam int unsigned SLOT_W = $clog2(FETCH_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        stall_i,
  input  logic [1:0]        halt_i,
  input  logic [1:0]        wake_i,
  input  logic [1:0]        redir_valid_i,
  input  logic [ADDR_W-1:0] redir_addr0_i,
  input  logic [ADDR_W-1:0] redir_addr1_i,
  input  logic [1:0]        dec_pend_i,
  input  logic              dec_take_i,
  output logic              fetch_valid_o,
  output logic              fetch_tid_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SLOT_W-1:0] fetch_slots_o,
  output logic              dec_tid_o,
  output logic              dec_valid_o
);
  logic [ADDR_W-1:0] redir_addr [NUM_THREADS];
  logic [ADDR_W-1:0] ptr        [NUM_THREADS];
  logic [SLOT_W-1:0] slots      [NUM_THREADS];
  logic [1:0]        grant;
  logic [1:0]        elig;
  logic [1:0]        halted;
  tid_t              gtid;
  tid_t              dtid;

  assign redir_addr[0] = redir_addr0_i;
  assign redir_addr[1] = redir_addr1_i;

  smt_fetch_grant u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_i  (stall_i),
    .halt_i   (halt_i),
    .wake_i   (wake_i),
    .valid_o  (fetch_valid_o),
    .tid_o    (gtid),
    .grant_o  (grant),
    .elig_o   (elig),
    .halted_o (halted)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ptr
    smt_fetch_ptr #(
      .ADDR_W     (ADDR_W),
      .INSN_BYTES (INSN_BYTES),
      .FETCH_W    (FETCH_W),
      .RESET_VEC  (RESET_VEC)
    ) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .grant_i      (grant[t]),
      .redir_i      (redir_valid_i[t]),
      .redir_addr_i (redir_addr[t]),
      .ptr_o        (ptr[t]),
      .slots_o      (slots[t])
    );
  end

  smt_decode_sel #(
    .DEC_QUANTUM (DEC_QUANTUM)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (dec_pend_i),
    .take_i  (dec_take_i),
    .tid_o   (dtid),
    .valid_o (dec_valid_o)
  );

  assign fetch_tid_o   = gtid;
  assign fetch_addr_o  = ptr[gtid];
  assign fetch_slots_o = slots[gtid];
  assign dec_tid_o     = dtid;

  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&elig && $past(fetch_valid_o) && $past(rst_n)) |-> (fetch_tid_o != $past(fetch_tid_o)));
  p_stall_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i == 2'b01 && !halted[1]) |-> (fetch_valid_o && fetch_tid_o));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_i | halted) == 2'b11) |-> !fetch_valid_o);
  p_single_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted == 2'b01 && !stall_i[1]) |-> (fetch_valid_o && fetch_tid_o));
  p_first_grant_r1: assert property (@(posedge clk)
    (!$past(rst_n) && rst_n && stall_i == 2'b00 && halted == 2'b00) |-> (fetch_tid_o == 1'b0));
endmodule

// File: tb/tb_smt_fetch_arbiter.sv
module tb_smt_fetch_arbiter;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  stall_i = '0, halt_i = '0, wake_i = '0, redir_valid_i = '0, dec_pend_i = '0;
  logic [31:0] redir_addr0_i = '0, redir_addr1_i = '0;
  logic        dec_take_i = 1'b0;
  logic        fetch_valid_o, fetch_tid_o, dec_tid_o, dec_valid_o;
  logic [31:0] fetch_addr_o;
  logic [2:0]  fetch_slots_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_ptr [2];
  bit          m_halt [2];
  int          m_prev, m_cur, m_cnt;
  string       phase = "";

  always #4 clk = ~clk;

  smt_fetch_arbiter dut (.*);

  function automatic int slots_of(input logic [31:0] a);
    return 4 - int'((a >> 2) & 32'd3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr[0] = RV; m_ptr[1] = RV;
    m_halt[0] = 0; m_halt[1] = 0;
    m_prev = 1; m_cur = 0; m_cnt = 0;
  endtask

  // inputs already driven after negedge; compare, then advance model
  task automatic step();
    bit e0, e1, ev;
    int et, o;
    string ttag;
    #1;
    e0 = !m_halt[0] && !stall_i[0];
    e1 = !m_halt[1] && !stall_i[1];
    ev = e0 || e1;
    if (e0 && e1) et = (m_prev == 0) ? 1 : 0;
    else          et = e1 ? 1 : 0;
    if (m_halt[0] || m_halt[1]) ttag = "R5";
    else if (stall_i != 0)      ttag = "R4";
    else                        ttag = "R2";
    chk("R7", 32'(fetch_valid_o), 32'(ev));
    if (ev) begin
      chk(ttag, 32'(fetch_tid_o), 32'(et));
      chk("R3", fetch_addr_o, m_ptr[et]);
      chk("R11", 32'(fetch_slots_o), 32'(slots_of(m_ptr[et])));
    end
    chk(dec_pend_i[m_cur] ? "R9" : "R10", 32'(dec_tid_o), 32'(m_cur));
    chk("R9", 32'(dec_valid_o), 32'(dec_pend_i[m_cur]));
    // next state
    for (int t = 0; t < 2; t++) begin
      if (redir_valid_i[t])
        m_ptr[t] = (t == 0 ? redir_addr0_i : redir_addr1_i) & 32'hFFFF_FFFC;
      else if (ev && et == t)
        m_ptr[t] = (m_ptr[t] | 32'hF) + 32'd1;
      if (wake_i[t])      m_halt[t] = 0;
      else if (halt_i[t]) m_halt[t] = 1;
    end
    if (ev) m_prev = et;
    if (dec_pend_i[m_cur] && dec_take_i) m_cnt++;
    o = 1 - m_cur;
    if (dec_pend_i[o] && (!dec_pend_i[m_cur] || m_cnt == 8)) begin
      m_cur = o; m_cnt = 0;
    end else if (m_cnt == 8) m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic clr();
    stall_i = '0; halt_i = '0; wake_i = '0; redir_valid_i = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    phase = "R1 reset";
    #1;
    chk("R1", fetch_addr_o, RV);
    chk("R1", 32'(fetch_tid_o), 32'd0);
    chk("R1", 32'(dec_tid_o), 32'd0);
    rst_n = 1'b1;
    step();
    phase = "R2 alternate";
    repeat (5) step();
    phase = "R4 stall";
    stall_i = 2'b01; repeat (3) step();
    stall_i = 2'b10; repeat (2) step();
    phase = "R7 idle";
    stall_i = 2'b11; repeat (3) step();
    clr();
    phase = "R5 halt";
    halt_i = 2'b10; step(); clr();
    repeat (4) step();
    phase = "R6 wake";
    wake_i = 2'b10; halt_i = 2'b10; step(); clr();
    repeat (4) step();
    halt_i = 2'b01; step(); clr();
    stall_i = 2'b10; repeat (2) step(); clr();
    wake_i = 2'b01; step(); clr();
    repeat (2) step();
    phase = "R8 redirect";
    redir_valid_i = 2'b01; redir_addr0_i = 32'h0000_200B; step(); clr();
    repeat (3) step();
    redir_valid_i = 2'b10; redir_addr1_i = 32'h0000_3004; stall_i = 2'b01; step(); clr();
    repeat (3) step();
    phase = "R9 quantum";
    dec_pend_i = 2'b11; dec_take_i = 1'b1; repeat (20) step();
    dec_pend_i = 2'b01; repeat (12) step();
    phase = "R10 early";
    dec_pend_i = 2'b10; repeat (3) step();
    dec_pend_i = 2'b01; repeat (3) step();
    phase = "random";
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      stall_i       = {($urandom % 4) == 0, ($urandom % 4) == 0};
      halt_i        = {($urandom % 40) == 0, ($urandom % 40) == 0};
      wake_i        = {($urandom % 12) == 0, ($urandom % 12) == 0};
      redir_valid_i = {($urandom % 16) == 0, ($urandom % 16) == 0};
      redir_addr0_i = $urandom;
      redir_addr1_i = $urandom;
      dec_pend_i    = {($urandom % 3) != 0, ($urandom % 3) != 0};
      dec_take_i    = ($urandom % 4) != 0;
      step();
    end
    done = 1;
    summary();
  end
endmodule